// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine takes incoming frames from a byte-wide valid/ready stream and places each one into shared memory. The memory holds a ring of 16 descriptors, 8 bytes each, and one fixed-size buffer per descriptor. The engine looks for the next descriptor that the host has handed over and copies the frame bytes into that descriptor's buffer. It then writes the received length into the descriptor and returns the descriptor to the host by rewriting its status byte. Each completed frame sets a sticky receive flag. A frame that finds no usable descriptor is drained and sets a sticky miss flag. Both flags feed a summary flag and an enable-gated interrupt.

While the engine is idle, it reads the status bytes of the ring one after another. It keeps a per-entry record of which descriptors it currently owns, and from that record it reports a capacity figure: the buffer size when at least one descriptor is owned, and zero otherwise. A stop input discards arriving frames and forces the capacity figure to zero.

The memory port is byte-wide with a read latency of one cycle. A read issued in one cycle returns its data during the next cycle. Descriptor `i` starts at `ring_base + 8*i`. Its buffer starts at `buf_base + i*1544`.

Top module: `rxr_ring_writer`

## Requirements
- R1: `rx_room` is 1544 when any descriptor's status byte (offset 2) equals exactly 0x80 and `stopped` is low; otherwise it is 0. Values such as 0x81 or 0x03 do not count. The figure follows memory within 40 idle cycles.
- R2: While `stopped` is high, an arriving frame is accepted and discarded. Nothing is written to memory, and neither flag changes.
- R3: The search begins at the saved ring index and moves forward modulo 16 over 15 entries, so the entry just before the start is never examined. The first entry whose status is exactly 0x80 is used.
- R4: Each stored frame advances the saved ring index by exactly one, wherever in the search window the descriptor was found.
- R5: Byte k of a frame is written to `buf_base + i*1544 + k` for the chosen entry i.
- R6: After the data, the byte count is written to descriptor offset 6 (bits 15:8) and offset 7 (bits 7:0). The status byte at offset 2 is then written as 0x03, and this is the last memory write of the frame.
- R7: Completing a frame sets `rx_flag`. `intr` is the OR of `rx_flag` and `miss_flag`, and `irq` equals `intr` AND `int_en`.
- R8: When no descriptor is usable, the whole frame is consumed, nothing is written to memory, and `miss_flag` is set.
- R9: A frame longer than 1544 bytes stores its first 1544 bytes, reports a length of 1544, and consumes the rest without writing it.
- R10: `flag_clr[0]` clears `rx_flag` and `flag_clr[1]` clears `miss_flag`, taking effect on the next clock edge.
- R11: After reset, both flags and `irq` are low, `s_ready` is low, and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stopped | input | 1 | Controller stopped: frames discarded, capacity zero |
| int_en | input | 1 | Interrupt enable |
| flag_clr | input | 2 | Write-one-clear: bit 0 receive flag, bit 1 miss flag |
| ring_base | input | AW | Byte address of descriptor 0 |
| buf_base | input | AW | Byte address of buffer 0 |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Stream byte accepted |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |
| rx_room | output | 16 | Capacity: 1544 or 0 |
| rx_flag | output | 1 | Sticky frame-received flag |
| miss_flag | output | 1 | Sticky frame-missed flag |
| intr | output | 1 | OR of the sticky flags |
| irq | output | 1 | Interrupt request |

## Verification
The last byte of a stored frame is accepted on some clock edge. The three descriptor writes then follow on the next three edges, and `rx_flag` rises together with the status write. The bench therefore waits five falling edges after the final handshake before it reads memory, the flags and `irq`. A miss frame or a discarded frame sets its flag no later than the last handshake, so the same wait covers those cases. The capacity figure depends on a 16-entry idle scan with a one-cycle read. After the bench changes any status byte, it waits 40 cycles before it compares `rx_room`. Flag clears are checked one falling edge after the clear pulse.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PROBE  = 3'd1,
      ST_PWAIT  = 3'd2,
      ST_DATA   = 3'd3,
      ST_LEN_HI = 3'd4,
      ST_LEN_LO = 3'd5,
      ST_STAT   = 3'd6,
      ST_DROP   = 3'd7
   } rxr_state_e;

   localparam logic [7:0] HOST_GAVE  = 8'h80;
   localparam logic [7:0] FRAME_DONE = 8'h03;
   localparam logic [2:0] OFF_STAT   = 3'd2;
   localparam logic [2:0] OFF_LEN_HI = 3'd6;
   localparam logic [2:0] OFF_LEN_LO = 3'd7;
endpackage

// File: rtl/rxr_own_track.sv
module rxr_own_track #(
   parameter int RING = 16,
   localparam int IW = $clog2(RING)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_go,
   output logic [IW-1:0]   scan_idx,
   input  logic [7:0]      rdata,
   input  logic            rel_en,
   input  logic [IW-1:0]   rel_idx,
   output logic [RING-1:0] owned
);
   import rxr_pkg::*;

   logic [IW-1:0] pend_idx;
   logic          pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_idx <= '0;
         pend_idx <= '0;
         pend     <= 1'b0;
      end else begin
         pend <= scan_go;
         if (scan_go) begin
            pend_idx <= scan_idx;
            scan_idx <= scan_idx + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < RING; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            owned[g] <= 1'b0;
         else if (rel_en && rel_idx == IW'(g))
            owned[g] <= 1'b0;
         else if (pend && pend_idx == IW'(g))
            owned[g] <= (rdata == HOST_GAVE);
      end
   end
endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen #(
   parameter int AW        = 24,
   parameter int RING      = 16,
   parameter int BUF_BYTES = 1544,
   localparam int IW = $clog2(RING),
   localparam int CW = $clog2(BUF_BYTES + 1)
) (
   input  logic [AW-1:0] ring_base,
   input  logic [AW-1:0] buf_base,
   input  logic [IW-1:0] d_idx,
   input  logic [2:0]    d_off,
   input  logic [IW-1:0] b_idx,
   input  logic [CW-1:0] b_cnt,
   output logic [AW-1:0] desc_addr,
   output logic [AW-1:0] buf_addr
);
   always_comb begin
      desc_addr = ring_base + AW'({d_idx, 3'b000}) + AW'(d_off);
      buf_addr  = buf_base + AW'(b_idx) * AW'(BUF_BYTES) + AW'(b_cnt);
   end
endmodule

// File: rtl/rxr_evt_flags.sv
module rxr_evt_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_rx,
   input  logic       set_miss,
   input  logic [1:0] clr,
   input  logic       int_en,
   output logic       rx_flag,
   output logic       miss_flag,
   output logic       intr,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flag   <= 1'b0;
         miss_flag <= 1'b0;
      end else begin
         if (set_rx)      rx_flag <= 1'b1;
         else if (clr[0]) rx_flag <= 1'b0;
         if (set_miss)    miss_flag <= 1'b1;
         else if (clr[1]) miss_flag <= 1'b0;
      end
   end

   assign intr = rx_flag | miss_flag;
   assign irq  = intr & int_en;
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
   parameter int AW        = 24,
   parameter int RING      = 16,
   parameter int BUF_BYTES = 1544,
   localparam int IW = $clog2(RING),
   localparam int CW = $clog2(BUF_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stopped,
   input  logic          int_en,
   input  logic [1:0]    flag_clr,
   input  logic [AW-1:0] ring_base,
   input  logic [AW-1:0] buf_base,
   input  logic          s_valid,
   input  logic [7:0]    s_data,
   input  logic          s_last,
   output logic          s_ready,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic [15:0]   rx_room,
   output logic          rx_flag,
   output logic          miss_flag,
   output logic          intr,
   output logic          irq
);
   import rxr_pkg::*;

   if (RING < 2 || (RING & (RING - 1)) != 0) begin : g_bad_ring
      $error("RING must be a power of two of at least 2");
   end
   if (BUF_BYTES < 1 || BUF_BYTES > 65535) begin : g_bad_buf
      $error("BUF_BYTES must fit the 16-bit length field");
   end
   if (AW < IW + 3) begin : g_bad_aw
      $error("AW too narrow for the ring");
   end

   localparam logic [IW-1:0] LAST_PROBE = IW'(RING - 2);

   rxr_state_e    state;
   logic [IW-1:0] rx_idx, probe_idx, probe_n, cur_idx, scan_idx, d_idx;
   logic [CW-1:0] count;
   logic [2:0]    d_off;
   logic [AW-1:0] desc_addr, buf_addr;
   logic [RING-1:0] owned;
   logic [15:0]   len16;
   logic          full, hit, set_miss, set_rx;

   assign full     = (count == CW'(BUF_BYTES));
   assign hit      = (mem_rdata == HOST_GAVE);
   assign len16    = 16'(count);
   assign s_ready  = (state == ST_DATA) || (state == ST_DROP);
   assign set_miss = (state == ST_PWAIT) && !hit && (probe_n == LAST_PROBE);
   assign set_rx   = (state == ST_STAT);
   assign rx_room  = (|owned && !stopped) ? 16'(BUF_BYTES) : 16'd0;

   rxr_own_track #(.RING(RING)) u_track (
      .clk(clk), .rst_n(rst_n), .scan_go(state == ST_IDLE), .scan_idx(scan_idx),
      .rdata(mem_rdata), .rel_en(set_rx), .rel_idx(cur_idx), .owned(owned)
   );

   rxr_addr_gen #(.AW(AW), .RING(RING), .BUF_BYTES(BUF_BYTES)) u_addr (
      .ring_base(ring_base), .buf_base(buf_base), .d_idx(d_idx), .d_off(d_off),
      .b_idx(cur_idx), .b_cnt(count), .desc_addr(desc_addr), .buf_addr(buf_addr)
   );

   rxr_evt_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_miss(set_miss), .clr(flag_clr),
      .int_en(int_en), .rx_flag(rx_flag), .miss_flag(miss_flag), .intr(intr), .irq(irq)
   );

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = 8'h00;
      d_idx     = cur_idx;
      d_off     = OFF_STAT;
      unique case (state)
         ST_IDLE:   begin mem_en = 1'b1; d_idx = scan_idx; end
         ST_PROBE:  begin mem_en = 1'b1; d_idx = probe_idx; end
         ST_DATA:   begin
            mem_en    = s_valid && !full;
            mem_we    = s_valid && !full;
            mem_wdata = s_data;
         end
         ST_LEN_HI: begin mem_en = 1'b1; mem_we = 1'b1; d_off = OFF_LEN_HI; mem_wdata = len16[15:8]; end
         ST_LEN_LO: begin mem_en = 1'b1; mem_we = 1'b1; d_off = OFF_LEN_LO; mem_wdata = len16[7:0]; end
         ST_STAT:   begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = FRAME_DONE; end
         default:   ;
      endcase
      mem_addr = (state == ST_DATA) ? buf_addr : desc_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rx_idx    <= '0;
         probe_idx <= '0;
         probe_n   <= '0;
         cur_idx   <= '0;
         count     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (s_valid) begin
               if (stopped) state <= ST_DROP;
               else begin
                  probe_idx <= rx_idx;
                  probe_n   <= '0;
                  state     <= ST_PROBE;
               end
            end
            ST_PROBE: state <= ST_PWAIT;
            ST_PWAIT: begin
               if (hit) begin
                  cur_idx <= probe_idx;
                  rx_idx  <= rx_idx + 1'b1;
                  count   <= '0;
                  state   <= ST_DATA;
               end else if (probe_n == LAST_PROBE) begin
                  state <= ST_DROP;
               end else begin
                  probe_idx <= probe_idx + 1'b1;
                  probe_n   <= probe_n + 1'b1;
                  state     <= ST_PROBE;
               end
            end
            ST_DATA: if (s_valid) begin
               if (!full) count <= count + 1'b1;
               if (s_last) state <= ST_LEN_HI;
            end
            ST_LEN_HI: state <= ST_LEN_LO;
            ST_LEN_LO: state <= ST_STAT;
            ST_STAT:   state <= ST_IDLE;
            ST_DROP:   if (s_valid && s_last) state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
   parameter int BUF_BYTES = 1544
) (
   input logic        clk,
   input logic        rst_n,
   input logic        stopped,
   input logic        int_en,
   input logic [15:0] rx_room,
   input logic        rx_flag,
   input logic        intr,
   input logic        irq,
   input logic        mem_en,
   input logic        mem_we,
   input logic [7:0]  mem_wdata,
   input logic [2:0]  st
);
   import rxr_pkg::*;

   // R1
   room_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_room == 16'd0) || (rx_room == 16'(BUF_BYTES)));

   // R1
   room_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> (rx_room == 16'd0));

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (int_en && intr));

   // R6
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $past(mem_en && mem_we && mem_wdata == FRAME_DONE));

   // R8
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'(ST_DROP)) |-> !mem_we);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .stopped(stopped), .int_en(int_en), .rx_room(rx_room),
   .rx_flag(rx_flag), .intr(intr), .irq(irq), .mem_en(mem_en), .mem_we(mem_we),
   .mem_wdata(mem_wdata), .st(state)
);

// File: tb/rxr_ring_writer_bench.sv
module rxr_ring_writer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int RB = 32'h1000;
   localparam int BB = 32'h2000;
   localparam int BSZ = 1544;

   logic clk = 1'b0, rst_n = 1'b0, stopped = 1'b0, int_en = 1'b0;
   logic [1:0] flag_clr = 2'b00;
   logic s_valid = 1'b0, s_last = 1'b0, s_ready;
   logic [7:0] s_data = 8'h00;
   logic mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata = 8'h00;
   logic [15:0] rx_room;
   logic rx_flag, miss_flag, intr, irq;

   bit [7:0] mem [int];
   bit [7:0] fr [0:1699];
   int wr_cnt = 0, last_wr = 0, n_cmp = 0, n_bad = 0, cyc = 0;
   int exp_idx = 0;
   bit exp_rx = 0, exp_miss = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rxr_ring_writer #(.AW(AW)) u_rxr_ring_writer (
      .clk(clk), .rst_n(rst_n), .stopped(stopped), .int_en(int_en), .flag_clr(flag_clr),
      .ring_base(AW'(RB)), .buf_base(AW'(BB)), .s_valid(s_valid), .s_data(s_data),
      .s_last(s_last), .s_ready(s_ready), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rx_room(rx_room), .rx_flag(rx_flag), .miss_flag(miss_flag), .intr(intr), .irq(irq)
   );

   always @(posedge clk) begin
      cyc++;
      if (mem_en) begin
         if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
            last_wr = int'(mem_addr);
         end else begin
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
         summary();
      end
   end

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int st_addr(int e);
      return RB + 8 * e + 2;
   endfunction

   function automatic int find_entry(int start);
      for (int k = 0; k < 15; k++) begin
         int e = (start + k) % 16;
         if (mem.exists(st_addr(e)) && mem[st_addr(e)] == 8'h80) return e;
      end
      return -1;
   endfunction

   function automatic int any_owned();
      for (int e = 0; e < 16; e++)
         if (mem.exists(st_addr(e)) && mem[st_addr(e)] == 8'h80) return 1;
      return 0;
   endfunction

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(int len);
      for (int k = 0; k < len; k++) begin
         bit rdy;
         s_valid = 1'b1; s_data = fr[k]; s_last = (k == len - 1);
         forever begin
            #1 rdy = s_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
         end
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic check_room();
      wait_n(40);
      chk("R1 rx_room", int'(rx_room), (any_owned() && !stopped) ? BSZ : 0);
   endtask

   task automatic frame(int len);
      int e, w0, n, errs, rx0, ms0;
      for (int k = 0; k < len; k++) fr[k] = 8'($urandom);
      e = stopped ? -2 : find_entry(exp_idx);
      w0 = wr_cnt; rx0 = rx_flag; ms0 = miss_flag;
      send(len);
      wait_n(5);
      if (e == -2) begin
         chk("R2 writes while stopped", wr_cnt - w0, 0);
         chk("R2 flags while stopped", {rx_flag, miss_flag}, {rx0[0], ms0[0]});
      end else if (e == -1) begin
         exp_miss = 1;
         chk("R8 writes on miss", wr_cnt - w0, 0);
         chk("R8 miss_flag", miss_flag, 1);
      end else begin
         n = (len > BSZ) ? BSZ : len;
         errs = 0;
         for (int k = 0; k < n; k++)
            if (mem[BB + e * BSZ + k] != fr[k]) errs++;
         chk("R5 buffer bytes wrong", errs, 0);
         chk("R9 write count", wr_cnt - w0, n + 3);
         chk("R6 length", {mem[RB + 8 * e + 6], mem[RB + 8 * e + 7]}, n);
         chk("R6 status", mem[st_addr(e)], 8'h03);
         chk("R6 last write address", last_wr, st_addr(e));
         exp_idx = (exp_idx + 1) % 16;
         exp_rx = 1;
         chk("R7 rx_flag", rx_flag, 1);
      end
      chk("R7 intr", intr, int'(exp_rx | exp_miss));
      chk("R7 irq", irq, int'((exp_rx | exp_miss) & int_en));
   endtask

   task automatic clear(logic [1:0] v);
      @(negedge clk); flag_clr = v;
      @(negedge clk); flag_clr = 2'b00;
      if (v[0]) exp_rx = 0;
      if (v[1]) exp_miss = 0;
      chk("R10 rx_flag after clear", rx_flag, int'(exp_rx));
      chk("R10 miss_flag after clear", miss_flag, int'(exp_miss));
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int e = 0; e < 16; e++) mem[st_addr(e)] = 8'h00;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R11 reset state
      chk("R11 rx_flag", rx_flag, 0);
      chk("R11 miss_flag", miss_flag, 0);
      chk("R11 irq", irq, 0);
      chk("R11 s_ready", s_ready, 0);
      check_room();

      // R8 nothing owned, then R7 gating and R10 clear
      frame(12);
      int_en = 1'b1; #1;
      chk("R7 irq enabled", irq, 1);
      clear(2'b10);
      chk("R10 irq after clear", irq, 0);

      // R1 and R2
      for (int e = 0; e < 4; e++) mem[st_addr(e)] = 8'h80;
      check_room();
      stopped = 1'b1;
      check_room();
      frame(9);
      stopped = 1'b0;

      // R3 R5 R6 first entry
      frame(20);
      clear(2'b01);

      // R4 index advances by one only
      for (int e = 1; e < 4; e++) mem[st_addr(e)] = 8'h00;
      mem[st_addr(9)] = 8'h80;
      frame(7);
      chk("R4 entry 9 used", mem[st_addr(9)], 8'h03);
      mem[st_addr(10)] = 8'h80;
      mem[st_addr(1)] = 8'h80;
      frame(5);
      chk("R4 search from index 2 took entry 10", mem[st_addr(10)], 8'h03);
      chk("R4 entry 1 left owned", mem[st_addr(1)], 8'h80);

      // R3 entry before start index is skipped
      mem[st_addr(1)] = 8'h00;
      mem[st_addr(2)] = 8'h80;
      check_room();
      frame(6);
      chk("R3 entry 2 untouched", mem[st_addr(2)], 8'h80);
      clear(2'b11);

      // R1 status 0x81 is not usable
      mem[st_addr(2)] = 8'h81;
      check_room();

      // R9 truncation
      mem[st_addr(3)] = 8'h80;
      check_room();
      frame(1600);

      // random mix
      for (int it = 0; it < 14; it++) begin
         for (int e = 0; e < 16; e++) begin
            int r = $urandom_range(0, 9);
            mem[st_addr(e)] = (r < 3) ? 8'h80 : (r < 6) ? 8'h03 : (r < 8) ? 8'h81 : 8'h00;
         end
         int_en = 1'($urandom);
         check_room();
         frame($urandom_range(1, 64));
         if (it % 4 == 3) clear(2'($urandom));
      end
      summary();
   end
endmodule